// File: doc/BRIEF.md
# Pixel-Offset Video Timing Engine

This block generates the raster timing for a display port from the pixel clock. The position inside a frame is held as one running pixel count that starts at zero on enable and wraps at the programmed frame period. A second count gives the horizontal position within the current line. All vertical boundaries (sync width, display window rows, active window rows, fetch point) are programmed as absolute pixel offsets into the frame. Software computes them as a number of lines times the line period, plus an optional horizontal skew. The engine therefore compares positions and never multiplies.

The engine drives horizontal sync, vertical sync and data enable, each with its own programmable polarity. It also drives a pixel output and a one-cycle fetch strobe at a programmed frame offset. It accepts an upstream pixel stream through a valid/ready handshake and requests a pixel only inside the active window. When the active window is narrower than the display window, it fills the margin with a border colour. If the stream has no pixel for an active position, it outputs an underflow colour. A small word-addressed register port sets up the engine and reads back the frame and line counters. Every timing word passes through a shadow copy that updates only at a frame boundary or while the engine is stopped, so a reprogrammed frame never tears.

Top module: `disp_timing_engine`

## Requirements
- R1: After reset, and whenever the enable bit (bit 0 of the control word, address 0) is clear, the position counts are zero and both counters read as zero. The sync and data-enable pins sit at their polarity-bit levels, the pixel output is zero, and ready and the fetch strobe are low.
- R2: While enabled, the horizontal position runs 0 to P−1 and wraps, where P is bits [31:16] of the line word (address 2). Horizontal sync is asserted while the position is below bits [15:0] of that word.
- R3: While enabled, the frame pixel count runs 0 to F−1 and wraps, where F is the frame-period word (address 3). Vertical sync is asserted while the count is below the sync-width word (address 4).
- R4: Data enable and the pixel output are driven when the horizontal position lies within [start, end] of the display column word (address 5: end in [31:16], start in [15:0]). The frame count must also lie within the display start and end offsets (addresses 6 and 7, inclusive). Outside that window the pixel output is zero.
- R5: The active window is the display window narrowed to columns [start, end] of address 8 when config bit 29 is set, and to offsets [address 9, address 10] when config bit 30 is set. Ready is high only inside it. Display pixels outside it carry the border colour (address 11).
- R6: Inside the active window the pixel output is the input data when valid is high, and the underflow colour (address 12) when it is low.
- R7: Polarity word (address 13) bit 0 inverts horizontal sync, bit 1 inverts vertical sync and bit 2 inverts data enable.
- R8: With config bit 31 set, the fetch strobe is high for exactly the cycle in which the frame count equals the fetch word (address 14).
- R9: The frame counter (address 15) counts frame wraps, and the line counter (address 16) counts line wraps and clears at each frame wrap. Both advance only while config bits 0 and 1 are both set, and otherwise hold.
- R10: A register write reads back at once but steers the timing only after the next frame wrap, or after one cycle while the engine is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| in_valid | input | 1 | Upstream pixel present |
| in_data | input | PIX_W | Upstream pixel value |
| in_ready | output | 1 | Pixel requested (active window) |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_data | output | PIX_W | Output pixel |
| fetch_strobe | output | 1 | Programmable fetch pulse |

## Verification
The hardest behaviour to reach from the ports is a write that lands partway through a running frame. The readback must change at once while the outputs must not change until the wrap. The stimulus rewrites the border colour and all three polarity bits in mid-frame, and later clears the counter-enable bits and the active-window bits in mid-frame. A cycle-accurate reference in the bench keeps its own shadow copy, so every pin of every cycle is compared through each transition.

// File: rtl/dte_pkg.sv
package dte_pkg;
    localparam int RA_W   = 5;
    localparam int WORD_W = 32;
    localparam int HPOS_W = 16;

    localparam int CFG_ACT_H = 29;
    localparam int CFG_ACT_V = 30;
    localparam int CFG_FETCH = 31;

    typedef enum logic [RA_W-1:0] {
        RA_CTRL    = 5'd0,
        RA_CFG     = 5'd1,
        RA_HCTL    = 5'd2,
        RA_FPER    = 5'd3,
        RA_VSW     = 5'd4,
        RA_DHWIN   = 5'd5,
        RA_DVSTART = 5'd6,
        RA_DVEND   = 5'd7,
        RA_AHWIN   = 5'd8,
        RA_AVSTART = 5'd9,
        RA_AVEND   = 5'd10,
        RA_BORDER  = 5'd11,
        RA_UFLOW   = 5'd12,
        RA_POL     = 5'd13,
        RA_FETCH   = 5'd14,
        RA_FCOUNT  = 5'd15,
        RA_LCOUNT  = 5'd16
    } reg_addr_e;

    typedef struct packed {
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] hctl;
        logic [WORD_W-1:0] fperiod;
        logic [WORD_W-1:0] vsw;
        logic [WORD_W-1:0] dhwin;
        logic [WORD_W-1:0] dvstart;
        logic [WORD_W-1:0] dvend;
        logic [WORD_W-1:0] ahwin;
        logic [WORD_W-1:0] avstart;
        logic [WORD_W-1:0] avend;
        logic [WORD_W-1:0] border;
        logic [WORD_W-1:0] uflow;
        logic [WORD_W-1:0] pol;
        logic [WORD_W-1:0] fetch;
    } timing_cfg_t;
endpackage

// File: rtl/dte_regs.sv
module dte_regs
    import dte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RA_W-1:0]   addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              frame_wrap,
    output logic              en,
    output timing_cfg_t       live,
    output timing_cfg_t       shadow
);
    typedef struct packed {
        logic        en;
        timing_cfg_t live;
        timing_cfg_t sh;
    } regs_st_t;

    regs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.en || frame_wrap) begin
            st_d.sh = st_q.live;
        end
        if (we) begin
            case (reg_addr_e'(addr))
                RA_CTRL:    st_d.en           = wdata[0];
                RA_CFG:     st_d.live.cfg     = wdata;
                RA_HCTL:    st_d.live.hctl    = wdata;
                RA_FPER:    st_d.live.fperiod = wdata;
                RA_VSW:     st_d.live.vsw     = wdata;
                RA_DHWIN:   st_d.live.dhwin   = wdata;
                RA_DVSTART: st_d.live.dvstart = wdata;
                RA_DVEND:   st_d.live.dvend   = wdata;
                RA_AHWIN:   st_d.live.ahwin   = wdata;
                RA_AVSTART: st_d.live.avstart = wdata;
                RA_AVEND:   st_d.live.avend   = wdata;
                RA_BORDER:  st_d.live.border  = wdata;
                RA_UFLOW:   st_d.live.uflow   = wdata;
                RA_POL:     st_d.live.pol     = wdata;
                RA_FETCH:   st_d.live.fetch   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign live   = st_q.live;
    assign shadow = st_q.sh;

    // R10: timing set is frozen inside a running frame
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && !frame_wrap) |=> $stable(st_q.sh));
endmodule

// File: rtl/dte_counter.sv
module dte_counter
    import dte_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  timing_cfg_t       cfg,
    output logic [CNT_W-1:0]  pix,
    output logic [HPOS_W-1:0] hpos,
    output logic [WORD_W-1:0] frame_cnt,
    output logic [WORD_W-1:0] line_cnt,
    output logic              frame_wrap
);
    typedef struct packed {
        logic [CNT_W-1:0]  pix;
        logic [HPOS_W-1:0] h;
        logic [WORD_W-1:0] fc;
        logic [WORD_W-1:0] lc;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    logic [CNT_W-1:0]  fp_last;
    logic [HPOS_W-1:0] hp_last;
    logic              line_wrap;
    logic              cnt_on;
    logic              unused_cfg;

    assign fp_last    = cfg.fperiod[CNT_W-1:0] - CNT_W'(1);
    assign hp_last    = cfg.hctl[31:16] - HPOS_W'(1);
    assign frame_wrap = en && (cnt_q.pix == fp_last);
    assign line_wrap  = en && (cnt_q.h == hp_last);
    assign cnt_on     = (cfg.cfg[1:0] == 2'b11);
    assign unused_cfg = ^cfg;

    always_comb begin
        cnt_d = cnt_q;
        if (!en) begin
            cnt_d = '0;
        end else begin
            cnt_d.pix = frame_wrap ? '0 : cnt_q.pix + CNT_W'(1);
            cnt_d.h   = (frame_wrap || line_wrap) ? '0 : cnt_q.h + HPOS_W'(1);
            if (cnt_on) begin
                cnt_d.fc = cnt_q.fc + WORD_W'(frame_wrap);
                cnt_d.lc = frame_wrap ? '0 : cnt_q.lc + WORD_W'(line_wrap);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pix       = cnt_q.pix;
    assign hpos      = cnt_q.h;
    assign frame_cnt = cnt_q.fc;
    assign line_cnt  = cnt_q.lc;

    // R1: a stopped engine parks at the origin
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pix == '0 && hpos == '0));
    // R3: frame position restarts after the last pixel
    p_pix_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (pix == '0));
    // R9: counters freeze while counting is switched off
    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_on) |=> ($stable(frame_cnt) && $stable(line_cnt)));
endmodule

// File: rtl/dte_window.sv
module dte_window
    import dte_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PIX_W = 24
) (
    input  logic              en,
    input  logic [CNT_W-1:0]  pix,
    input  logic [HPOS_W-1:0] hpos,
    input  timing_cfg_t       cfg,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    output logic              hs_act,
    output logic              vs_act,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix_out,
    output logic              ready,
    output logic              fetch
);
    logic disp_h, disp_v, disp;
    logic act_h, act_v, act;
    logic unused_cfg;

    assign unused_cfg = ^cfg;

    always_comb begin
        hs_act = en && (hpos < cfg.hctl[15:0]);
        vs_act = en && (pix < cfg.vsw[CNT_W-1:0]);
        disp_h = (hpos >= cfg.dhwin[15:0]) && (hpos <= cfg.dhwin[31:16]);
        disp_v = (pix >= cfg.dvstart[CNT_W-1:0]) && (pix <= cfg.dvend[CNT_W-1:0]);
        disp   = en && disp_h && disp_v;
        act_h  = !cfg.cfg[CFG_ACT_H] ||
                 ((hpos >= cfg.ahwin[15:0]) && (hpos <= cfg.ahwin[31:16]));
        act_v  = !cfg.cfg[CFG_ACT_V] ||
                 ((pix >= cfg.avstart[CNT_W-1:0]) && (pix <= cfg.avend[CNT_W-1:0]));
        act    = disp && act_h && act_v;

        if (!disp)         pix_out = '0;
        else if (!act)     pix_out = cfg.border[PIX_W-1:0];
        else if (in_valid) pix_out = in_data;
        else               pix_out = cfg.uflow[PIX_W-1:0];

        ready = act;
        fetch = en && cfg.cfg[CFG_FETCH] && (pix == cfg.fetch[CNT_W-1:0]);
        hsync = hs_act ^ cfg.pol[0];
        vsync = vs_act ^ cfg.pol[1];
        de    = disp   ^ cfg.pol[2];
    end
endmodule

// File: rtl/disp_timing_engine.sv
module disp_timing_engine
    import dte_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_data,
    output logic              in_ready,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix_data,
    output logic              fetch_strobe
);
    logic              en;
    timing_cfg_t       live, shadow;
    logic [CNT_W-1:0]  pix;
    logic [HPOS_W-1:0] hpos;
    logic [WORD_W-1:0] frame_cnt, line_cnt;
    logic              frame_wrap;
    logic              hs_act, vs_act;

    dte_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .frame_wrap(frame_wrap), .en(en),
        .live(live), .shadow(shadow)
    );

    dte_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(shadow), .pix(pix),
        .hpos(hpos), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
        .frame_wrap(frame_wrap)
    );

    dte_window #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_win (
        .en(en), .pix(pix), .hpos(hpos), .cfg(shadow),
        .in_valid(in_valid), .in_data(in_data), .hs_act(hs_act),
        .vs_act(vs_act), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_out(pix_data), .ready(in_ready), .fetch(fetch_strobe)
    );

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_CTRL:    reg_rdata = {31'b0, en};
            RA_CFG:     reg_rdata = live.cfg;
            RA_HCTL:    reg_rdata = live.hctl;
            RA_FPER:    reg_rdata = live.fperiod;
            RA_VSW:     reg_rdata = live.vsw;
            RA_DHWIN:   reg_rdata = live.dhwin;
            RA_DVSTART: reg_rdata = live.dvstart;
            RA_DVEND:   reg_rdata = live.dvend;
            RA_AHWIN:   reg_rdata = live.ahwin;
            RA_AVSTART: reg_rdata = live.avstart;
            RA_AVEND:   reg_rdata = live.avend;
            RA_BORDER:  reg_rdata = live.border;
            RA_UFLOW:   reg_rdata = live.uflow;
            RA_POL:     reg_rdata = live.pol;
            RA_FETCH:   reg_rdata = live.fetch;
            RA_FCOUNT:  reg_rdata = en ? frame_cnt : '0;
            RA_LCOUNT:  reg_rdata = en ? line_cnt : '0;
            default:    reg_rdata = '0;
        endcase
    end

    // R2: a sync pulse can only begin at the line origin
    p_hsync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_act) |-> (hpos == '0));
    // R3: vertical sync can only begin at the frame origin
    p_vsync_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> (pix == '0));
endmodule

// File: tb/disp_timing_engine_test.sv
`timescale 1ns/1ps
module disp_timing_engine_test;
    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_data = '0;
    logic          in_ready, hsync, vsync, de, fetch_strobe;
    logic [PW-1:0] pix_data;

    always #2.5 clk = ~clk;

    disp_timing_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .hsync(hsync), .vsync(vsync),
        .de(de), .pix_data(pix_data), .fetch_strobe(fetch_strobe)
    );

    typedef struct {
        logic          hs, vs, de, rdy, fetch;
        logic [PW-1:0] pix;
        logic [31:0]   rd;
    } exp_t;

    exp_t exp_q[$];
    int   n_total = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   done    = 0;

    // reference model
    logic [31:0] live [0:14];
    logic [31:0] sh   [0:14];
    logic        m_en = 0;
    logic [31:0] m_pix = 0, m_fc = 0, m_lc = 0;
    logic [15:0] m_h = 0;

    initial begin
        for (int i = 0; i < 15; i++) begin live[i] = 0; sh[i] = 0; end
    end

    always @(posedge clk) begin
        logic fw, hw, nen;
        if (!rst_n) begin
            m_en = 0; m_pix = 0; m_h = 0; m_fc = 0; m_lc = 0;
            for (int i = 0; i < 15; i++) begin live[i] = 0; sh[i] = 0; end
        end else begin
            fw  = m_en && (m_pix == sh[3] - 32'd1);
            hw  = m_en && (m_h == sh[2][31:16] - 16'd1);
            nen = m_en;
            if (!m_en) begin
                m_pix = 0; m_h = 0; m_fc = 0; m_lc = 0;
            end else begin
                m_pix = fw ? 0 : m_pix + 1;
                m_h   = (fw || hw) ? 16'd0 : m_h + 16'd1;
                if (sh[1][1:0] == 2'b11) begin
                    m_fc = m_fc + {31'b0, fw};
                    m_lc = fw ? 0 : m_lc + {31'b0, hw};
                end
            end
            if (!m_en || fw)
                for (int i = 1; i < 15; i++) sh[i] = live[i];
            if (reg_we) begin
                if (reg_addr == 0) nen = reg_wdata[0];
                else if (reg_addr < 15) live[reg_addr] = reg_wdata;
            end
            m_en = nen;
        end
    end

    // input pattern
    always @(negedge clk) begin
        cyc++;
        in_valid = (cyc % 3) != 0;
        in_data  = PW'(cyc * 7 + 32'h10101);
    end

    // expected-value producer
    always @(negedge clk) begin
        exp_t e;
        logic dh, dv, disp, ah, av, act;
        #1;
        e.hs = (m_en && m_h < sh[2][15:0]) ^ sh[13][0];
        e.vs = (m_en && m_pix < sh[4]) ^ sh[13][1];
        dh   = (m_h >= sh[5][15:0]) && (m_h <= sh[5][31:16]);
        dv   = (m_pix >= sh[6]) && (m_pix <= sh[7]);
        disp = m_en && dh && dv;
        ah   = !sh[1][29] || ((m_h >= sh[8][15:0]) && (m_h <= sh[8][31:16]));
        av   = !sh[1][30] || ((m_pix >= sh[9]) && (m_pix <= sh[10]));
        act  = disp && ah && av;
        e.de = disp ^ sh[13][2];
        e.rdy = act;
        if (!disp)         e.pix = '0;
        else if (!act)     e.pix = sh[11][PW-1:0];
        else if (in_valid) e.pix = in_data;
        else               e.pix = sh[12][PW-1:0];
        e.fetch = m_en && sh[1][31] && (m_pix == sh[14]);
        if (reg_addr == 0)       e.rd = {31'b0, m_en};
        else if (reg_addr == 15) e.rd = m_en ? m_fc : 0;
        else if (reg_addr == 16) e.rd = m_en ? m_lc : 0;
        else if (reg_addr < 15)  e.rd = live[reg_addr];
        else                     e.rd = 0;
        exp_q.push_back(e);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        exp_t e;
        #2;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            if (!rst_n) begin
                chk("R1 reset hsync", {31'b0, hsync}, {31'b0, e.hs});
                chk("R1 reset de", {31'b0, de}, {31'b0, e.de});
                chk("R1 reset pixel", {8'b0, pix_data}, {8'b0, e.pix});
                chk("R1 reset ready", {31'b0, in_ready}, {31'b0, e.rdy});
                chk("R1 reset readback", reg_rdata, e.rd);
            end else begin
                chk("R2/R7 hsync", {31'b0, hsync}, {31'b0, e.hs});
                chk("R3/R7 vsync", {31'b0, vsync}, {31'b0, e.vs});
                chk("R4/R7 de", {31'b0, de}, {31'b0, e.de});
                chk("R5 ready", {31'b0, in_ready}, {31'b0, e.rdy});
                chk("R4/R5/R6 pixel", {8'b0, pix_data}, {8'b0, e.pix});
                chk("R8 fetch", {31'b0, fetch_strobe}, {31'b0, e.fetch});
                chk("R9/R10 readback", reg_rdata, e.rd);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(4);
        @(negedge clk) rst_n = 1'b1;
        // programme while stopped: 10-pixel lines, 6-line frame
        wr(2,  {16'd10, 16'd1});
        wr(3,  32'd60);
        wr(4,  32'd10);
        wr(5,  {16'd7, 16'd2});
        wr(6,  32'd20);
        wr(7,  32'd49);
        wr(8,  {16'd5, 16'd3});
        wr(9,  32'd30);
        wr(10, 32'd39);
        wr(11, 32'h00AA00);
        wr(12, 32'hFF0000);
        wr(13, 32'd0);
        wr(14, 32'd5);
        wr(1,  32'hE000_0003);
        reg_addr = 5'd15;
        run(3);
        // R1: still stopped, counters read zero
        wr(0, 32'd1);
        reg_addr = 5'd16;
        run(125);
        reg_addr = 5'd15;
        run(7);
        // R10: mid-frame colour and polarity change
        wr(11, 32'h123456);
        wr(13, 32'd7);
        reg_addr = 5'd11;
        run(100);
        // R9: counting switched off mid-frame
        wr(1, 32'hE000_0000);
        reg_addr = 5'd16;
        run(70);
        reg_addr = 5'd15;
        run(20);
        // R5: active window follows display window
        wr(1, 32'h8000_0003);
        wr(13, 32'd0);
        reg_addr = 5'd16;
        run(130);
        // R1: stop engine, counters read zero
        wr(0, 32'd0);
        reg_addr = 5'd15;
        run(10);
        reg_addr = 5'd0;
        run(5);
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule